// File: doc/BRIEF.md
# Multiplexed Host Port

This block is a slave port through which an external host master reads and writes a processor's word-addressed internal memory. All host traffic crosses one 16-bit bus that carries addresses, data and control values alike. Every 32-bit quantity moves as two halfword transfers. A halfword flag marks each transfer as the low half or the high half. A 2-bit select code picks the target of each transfer: the control register, the address register, or the data path with or without address advance.

Inside the block are a read address register and a write address register, a 32-bit data word register and two small FIFOs. Host writes queue in a write FIFO that drains to the memory through a request/acknowledge port. Reads are served from a read FIFO that the block fills ahead of the host while bursting. A ready output holds the host off whenever the current transfer cannot finish. A shared control register carries an interrupt from the CPU to the host and one from the host to the CPU. The host strobes are assumed to be synchronous to `clk` already.

Top module: `muxhost_port`

## Requirements
- R1: After synchronous reset `hReady` is 1, `memReq` is 0, `hIrq` and `cpuIrq` are 0, and a control register read returns 0.
- R2: Control word bit 0 is the host interrupt and bit 1 is the CPU interrupt. A host control write with bit 1 set raises `cpuIrq`, and `cpuClrCpuIrq` lowers it. `cpuSetHostIrq` raises the host interrupt, and a host control write with bit 0 set clears it. A set wins over a clear in the same cycle. `hIrq` follows bit 0 whatever the state of `hSel`.
- R3: `hCtl` codes are 00 for control, 01 for data with address advance, 10 for the address register and 11 for data at a fixed address. A transfer with `hHalf`=0 carries bits 15:0 and one with `hHalf`=1 carries bits 31:16. A register changes only when its second half completes.
- R4: Control bit 2 (split) and bit 3 (pick) steer address writes. With split=0 an address write loads both registers. With split=1 it loads the read register when pick=0 and the write register when pick=1. An address read returns the write register only when split and pick are both 1, and the read register otherwise.
- R5: A completed data write queues the 32-bit word with the current write address. That word reaches memory with `memWe`=1, and every word ends up in memory at the address it was written to.
- R6: A fixed-address data write holds `hReady` low on its second half until no earlier write is queued or in flight.
- R7: An advancing data write holds `hReady` low only while the write FIFO is full, and it steps the write address by one per word.
- R8: A data read with `hHalf`=0 holds `hReady` low until a word is available and then returns bits 15:0 of that word. The following `hHalf`=1 read returns bits 31:16 of the same word.
- R9: An advancing read consumes the word, steps the read address by one, and keeps prefetching up to the read FIFO depth. A fixed-address read leaves the read address and the buffered word in place, so repeated reads return the same value.
- R10: Loading the read address or completing any data write discards all prefetched words and any fetch in flight. Queued writes reach memory before any later fetch is issued, so reads always observe earlier host writes.
- R11: `memReq` stays high with stable `memAddr`, `memWe` and `memWdata` until `memAck`, then drops for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hSel | input | 1 | Host chip select |
| hStb | input | 1 | Host transfer strobe, held until ready |
| hRead | input | 1 | 1 = host read, 0 = host write |
| hCtl | input | 2 | Transfer target select |
| hHalf | input | 1 | 0 = low halfword, 1 = high halfword |
| hWdata | input | 16 | Host write halfword |
| hRdata | output | 16 | Host read halfword |
| hReady | output | 1 | Transfer completes at this edge when high |
| hIrq | output | 1 | Interrupt to the host |
| cpuSetHostIrq | input | 1 | CPU pulse raising the host interrupt |
| cpuClrCpuIrq | input | 1 | CPU pulse clearing the CPU interrupt |
| cpuIrq | output | 1 | Interrupt to the CPU |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write word |
| memRdata | input | 32 | Memory read word, valid with memAck |
| memAck | input | 1 | One-cycle memory acknowledge |

## Verification
The properties assume that the host keeps `hStb`, `hSel`, `hRead`, `hCtl`, `hHalf` and `hWdata` steady from the moment it raises the strobe until an edge where `hReady` is high. They also assume that the memory raises `memAck` for exactly one cycle and only while `memReq` is high. The bench host tasks drive every field at a falling edge and hold it until ready has been seen. The bench memory model answers after a random or fixed delay with a single acknowledge cycle and clears it at the next falling edge. With these assumptions the hold and gap properties of the memory port, and the rule that only a host control write can raise the CPU interrupt, describe the block itself and not a misbehaving neighbour.

// File: rtl/muxhost_pkg.sv
package muxhost_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_DINC = 2'b01,
    SEL_ADDR = 2'b10,
    SEL_DFIX = 2'b11
  } selT;

  typedef enum logic [1:0] {
    MP_IDLE = 2'b00,
    MP_WR   = 2'b01,
    MP_RD   = 2'b10
  } memStT;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic latchLo;   // stage low halfword of a write
    logic ldCtrl;    // commit control word
    logic ldRdAddr;  // commit read address
    logic ldWrAddr;  // commit write address
    logic pushW;     // queue a data word
    logic incWr;     // step write address
    logic popW;      // write accepted by memory
    logic capWord;   // capture read FIFO head into data word
    logic consume;   // pop read FIFO head and step read address
    logic flushR;    // discard prefetched words
    logic pushR;     // store fetched word
    logic issueWr;   // launch memory write
    logic issueRd;   // launch memory fetch
  } strobeT;

endpackage

// File: rtl/muxhost_fifo.sv
module muxhost_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  // DEPTH must be a power of two, at least 2
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          doPush, doPop;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = store[rp];

  always_ff @(posedge clk) begin
    if (doPush && !flush) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (doPush) wp <= wp + 1'b1;
      if (doPop)  rp <= rp + 1'b1;
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/muxhost_ctrl.sv
module muxhost_ctrl
  import muxhost_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hSel,
  input  logic       hStb,
  input  logic       hRead,
  input  logic [1:0] hCtl,
  input  logic       hHalf,
  input  logic       wEmpty,
  input  logic       wFull,
  input  logic       rEmpty,
  input  logic       rFull,
  input  logic       addrSplit,
  input  logic       addrPick,
  input  logic       memAck,
  output strobeT     st,
  output logic       hReady,
  output logic       memReq,
  output logic       memWe
);

  memStT memSt;
  logic  armed, incMode, dropNext;
  logic  req, isData, okNow, xfer, wrDone, addrWr, rdFirst, fetchOk, ackRd;

  assign req    = hSel && hStb;
  assign isData = hCtl[0];

  always_comb begin
    okNow = 1'b1;
    if (hRead && isData && !hHalf)
      okNow = !rEmpty;
    else if (!hRead && isData && hHalf)
      okNow = (hCtl == SEL_DINC) ? !wFull : wEmpty;
  end

  assign hReady  = !req || okNow;
  assign xfer    = req && okNow;
  assign wrDone  = xfer && !hRead && hHalf;
  assign addrWr  = wrDone && (hCtl == SEL_ADDR);
  assign rdFirst = xfer && hRead && isData && !hHalf;
  assign fetchOk = armed && (incMode ? !rFull : rEmpty);
  assign ackRd   = (memSt == MP_RD) && memAck;

  always_comb begin
    st          = '0;
    st.latchLo  = xfer && !hRead && !hHalf;
    st.ldCtrl   = wrDone && (hCtl == SEL_CTRL);
    st.ldRdAddr = addrWr && (!addrSplit || !addrPick);
    st.ldWrAddr = addrWr && (!addrSplit || addrPick);
    st.pushW    = wrDone && isData;
    st.incWr    = wrDone && (hCtl == SEL_DINC);
    st.capWord  = rdFirst;
    st.consume  = rdFirst && (hCtl == SEL_DINC);
    st.flushR   = st.ldRdAddr || st.pushW;
    st.popW     = (memSt == MP_WR) && memAck;
    st.pushR    = ackRd && !dropNext && !st.flushR;
    st.issueWr  = (memSt == MP_IDLE) && !wEmpty;
    st.issueRd  = (memSt == MP_IDLE) && wEmpty && fetchOk && !st.flushR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memSt <= MP_IDLE;
    end else begin
      case (memSt)
        MP_IDLE: begin
          if (st.issueWr)      memSt <= MP_WR;
          else if (st.issueRd) memSt <= MP_RD;
        end
        default: if (memAck) memSt <= MP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      incMode  <= 1'b0;
      dropNext <= 1'b0;
    end else begin
      if (st.flushR) begin
        armed <= 1'b0;
      end else if (req && hRead && isData && !hHalf) begin
        armed   <= 1'b1;
        incMode <= (hCtl == SEL_DINC);
      end
      if (ackRd)
        dropNext <= 1'b0;
      else if (st.flushR && memSt == MP_RD)
        dropNext <= 1'b1;
    end
  end

  assign memReq = (memSt != MP_IDLE);
  assign memWe  = (memSt == MP_WR);

endmodule

// File: rtl/muxhost_dp.sv
module muxhost_dp
  import muxhost_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int WDEPTH = 4,
  parameter int RDEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  strobeT              st,
  input  logic [1:0]          hCtl,
  input  logic                hHalf,
  input  logic [HALF_W-1:0]   hWdata,
  output logic [HALF_W-1:0]   hRdata,
  input  logic                cpuSetHostIrq,
  input  logic                cpuClrCpuIrq,
  output logic                hostIrq,
  output logic                cpuIrq,
  input  logic [2*HALF_W-1:0] memRdata,
  output logic [2*HALF_W-1:0] memAddr,
  output logic [2*HALF_W-1:0] memWdata,
  output logic                wEmpty,
  output logic                wFull,
  output logic                rEmpty,
  output logic                rFull,
  output logic                addrSplit,
  output logic                addrPick
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int WENT_W = 2 * WORD_W;

  logic [HALF_W-1:0] stageLo;
  logic [WORD_W-1:0] newWord, rdAddr, wrAddr, pfAddr, dataWord, rHead, addrView;
  logic [WENT_W-1:0] wHead;
  logic [HALF_W-1:0] ctrlLo;

  assign newWord = {hWdata, stageLo};

  always_ff @(posedge clk) begin
    if (rst) begin
      stageLo   <= '0;
      hostIrq   <= 1'b0;
      cpuIrq    <= 1'b0;
      addrSplit <= 1'b0;
      addrPick  <= 1'b0;
      rdAddr    <= '0;
      wrAddr    <= '0;
      pfAddr    <= '0;
      dataWord  <= '0;
      memAddr   <= '0;
      memWdata  <= '0;
    end else begin
      if (st.latchLo) stageLo <= hWdata;

      if (cpuSetHostIrq)                  hostIrq <= 1'b1;
      else if (st.ldCtrl && stageLo[0])   hostIrq <= 1'b0;
      if (st.ldCtrl && stageLo[1])        cpuIrq  <= 1'b1;
      else if (cpuClrCpuIrq)              cpuIrq  <= 1'b0;
      if (st.ldCtrl) begin
        addrSplit <= stageLo[2];
        addrPick  <= stageLo[3];
      end

      if (st.ldRdAddr)      rdAddr <= newWord;
      else if (st.consume)  rdAddr <= rdAddr + 1'b1;

      if (st.ldWrAddr)      wrAddr <= newWord;
      else if (st.incWr)    wrAddr <= wrAddr + 1'b1;

      if (st.ldRdAddr)      pfAddr <= newWord;
      else if (st.flushR)   pfAddr <= rdAddr;
      else if (st.issueRd)  pfAddr <= pfAddr + 1'b1;

      if (st.capWord) dataWord <= rHead;

      if (st.issueWr) begin
        memAddr  <= wHead[WENT_W-1:WORD_W];
        memWdata <= wHead[WORD_W-1:0];
      end else if (st.issueRd) begin
        memAddr  <= pfAddr;
      end
    end
  end

  muxhost_fifo #(.W(WENT_W), .DEPTH(WDEPTH)) u_wfifo (
    .clk   (clk),
    .rst   (rst),
    .push  (st.pushW),
    .pop   (st.popW),
    .flush (1'b0),
    .din   ({wrAddr, newWord}),
    .head  (wHead),
    .empty (wEmpty),
    .full  (wFull)
  );

  muxhost_fifo #(.W(WORD_W), .DEPTH(RDEPTH)) u_rfifo (
    .clk   (clk),
    .rst   (rst),
    .push  (st.pushR),
    .pop   (st.consume),
    .flush (st.flushR),
    .din   (memRdata),
    .head  (rHead),
    .empty (rEmpty),
    .full  (rFull)
  );

  assign ctrlLo   = {{(HALF_W-4){1'b0}}, addrPick, addrSplit, cpuIrq, hostIrq};
  assign addrView = (addrSplit && addrPick) ? wrAddr : rdAddr;

  always_comb begin
    case (selT'(hCtl))
      SEL_CTRL: hRdata = hHalf ? '0 : ctrlLo;
      SEL_ADDR: hRdata = hHalf ? addrView[WORD_W-1:HALF_W] : addrView[HALF_W-1:0];
      default:  hRdata = hHalf ? dataWord[WORD_W-1:HALF_W] : rHead[HALF_W-1:0];
    endcase
  end

endmodule

// File: rtl/muxhost_port.sv
module muxhost_port
  import muxhost_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int WDEPTH = 4,
  parameter int RDEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hSel,
  input  logic                hStb,
  input  logic                hRead,
  input  logic [1:0]          hCtl,
  input  logic                hHalf,
  input  logic [HALF_W-1:0]   hWdata,
  output logic [HALF_W-1:0]   hRdata,
  output logic                hReady,
  output logic                hIrq,
  input  logic                cpuSetHostIrq,
  input  logic                cpuClrCpuIrq,
  output logic                cpuIrq,
  output logic                memReq,
  output logic                memWe,
  output logic [2*HALF_W-1:0] memAddr,
  output logic [2*HALF_W-1:0] memWdata,
  input  logic [2*HALF_W-1:0] memRdata,
  input  logic                memAck
);

  strobeT st;
  logic   wEmpty, wFull, rEmpty, rFull, addrSplit, addrPick;

  muxhost_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hSel      (hSel),
    .hStb      (hStb),
    .hRead     (hRead),
    .hCtl      (hCtl),
    .hHalf     (hHalf),
    .wEmpty    (wEmpty),
    .wFull     (wFull),
    .rEmpty    (rEmpty),
    .rFull     (rFull),
    .addrSplit (addrSplit),
    .addrPick  (addrPick),
    .memAck    (memAck),
    .st        (st),
    .hReady    (hReady),
    .memReq    (memReq),
    .memWe     (memWe)
  );

  muxhost_dp #(.HALF_W(HALF_W), .WDEPTH(WDEPTH), .RDEPTH(RDEPTH)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .st            (st),
    .hCtl          (hCtl),
    .hHalf         (hHalf),
    .hWdata        (hWdata),
    .hRdata        (hRdata),
    .cpuSetHostIrq (cpuSetHostIrq),
    .cpuClrCpuIrq  (cpuClrCpuIrq),
    .hostIrq       (hIrq),
    .cpuIrq        (cpuIrq),
    .memRdata      (memRdata),
    .memAddr       (memAddr),
    .memWdata      (memWdata),
    .wEmpty        (wEmpty),
    .wFull         (wFull),
    .rEmpty        (rEmpty),
    .rFull         (rFull),
    .addrSplit     (addrSplit),
    .addrPick      (addrPick)
  );

endmodule

// File: rtl/muxhost_chk.sv
module muxhost_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hSel,
  input logic              hStb,
  input logic              hRead,
  input logic [1:0]        hCtl,
  input logic              hHalf,
  input logic              hReady,
  input logic              hIrq,
  input logic              cpuSetHostIrq,
  input logic              cpuIrq,
  input logic              memReq,
  input logic              memWe,
  input logic [WORD_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              memAck
);

  logic ctrlCommit, fixWrCommit;
  assign ctrlCommit  = hSel && hStb && hReady && !hRead && hHalf && (hCtl == 2'b00);
  assign fixWrCommit = hSel && hStb && hReady && !hRead && hHalf && (hCtl == 2'b11);

  // R11: request fields hold until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R11: request drops after an acknowledge
  a_r11_req_gap: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck |=> !memReq);

  // R6: a fixed-address write completes only with no memory write in flight
  a_r6_fix_write_alone: assert property (@(posedge clk) disable iff (rst)
    fixWrCommit |-> !(memReq && memWe));

  // R2: only a host control commit raises the CPU interrupt
  a_r2_cpu_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(cpuIrq) |-> $past(ctrlCommit));

  // R2: the host interrupt falls only on a host control commit without a CPU set
  a_r2_host_irq_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(hIrq) |-> $past(ctrlCommit && !cpuSetHostIrq));

endmodule

bind muxhost_port muxhost_chk #(.WORD_W(2*HALF_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .hSel          (hSel),
  .hStb          (hStb),
  .hRead         (hRead),
  .hCtl          (hCtl),
  .hHalf         (hHalf),
  .hReady        (hReady),
  .hIrq          (hIrq),
  .cpuSetHostIrq (cpuSetHostIrq),
  .cpuIrq        (cpuIrq),
  .memReq        (memReq),
  .memWe         (memWe),
  .memAddr       (memAddr),
  .memWdata      (memWdata),
  .memAck        (memAck)
);

// File: tb/muxhost_port_bench.sv
module muxhost_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hSel = 1'b0, hStb = 1'b0, hRead = 1'b0, hHalf = 1'b0;
  logic [1:0]  hCtl = 2'b00;
  logic [15:0] hWdata = '0;
  logic [15:0] hRdata;
  logic        hReady, hIrq, cpuIrq, memReq, memWe;
  logic        cpuSetHostIrq = 1'b0, cpuClrCpuIrq = 1'b0;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #5 clk = ~clk;

  muxhost_port u_muxhost_port (.*);

  int total = 0;
  int bad   = 0;
  int latFix = -1;

  logic [31:0] ram  [256];
  logic [31:0] expm [256];
  logic [31:0] erd = '0, ewr = '0;
  bit          eSplit = 1'b0, ePick = 1'b0;

  function automatic logic [31:0] seedWord(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b, ~b, b ^ 8'h5A, 8'h3C};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // memory model: one ack cycle after a random or fixed delay
  initial begin : memModel
    int lat;
    bit seen;
    logic [31:0] reqA;
    logic reqW;
    lat = 0; seen = 0; reqA = '0; reqW = 1'b0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        seen = 0;
      end else if (memReq) begin
        if (!seen) begin
          seen = 1;
          reqA = memAddr;
          reqW = memWe;
          lat = (latFix >= 0) ? latFix : int'($urandom % 4);
        end
        if (lat > 0) lat--;
        else begin
          chk(memAddr == reqA && memWe == reqW, "R11 request stable", memAddr, reqA);
          if (memWe) ram[memAddr[7:0]] = memWdata;
          else memRdata = ram[memAddr[7:0]];
          memAck = 1'b1;
        end
      end
    end
  end

  task automatic xfer(input bit rd, input logic [1:0] ctl, input bit half,
                      input logic [15:0] wd, output logic [15:0] rv, output int waits);
    @(negedge clk);
    hSel = 1'b1; hStb = 1'b1; hRead = rd; hCtl = ctl; hHalf = half; hWdata = wd;
    waits = 0;
    forever begin
      #4;
      if (hReady) break;
      waits++;
      @(negedge clk);
    end
    rv = hRdata;
    @(posedge clk);
    #1;
    hSel = 1'b0; hStb = 1'b0;
  endtask

  task automatic wr32(input logic [1:0] ctl, input logic [31:0] w, output int waits);
    logic [15:0] d;
    int w0;
    xfer(1'b0, ctl, 1'b0, w[15:0], d, w0);
    xfer(1'b0, ctl, 1'b1, w[31:16], d, waits);
  endtask

  task automatic rd32(input logic [1:0] ctl, output logic [31:0] w, output int waits);
    logic [15:0] lo, hi;
    int w1;
    xfer(1'b1, ctl, 1'b0, 16'h0, lo, waits);
    xfer(1'b1, ctl, 1'b1, 16'h0, hi, w1);
    w = {hi, lo};
  endtask

  task automatic hSetCtrl(input logic [31:0] v);
    int w;
    wr32(2'b00, v, w);
    eSplit = v[2];
    ePick  = v[3];
  endtask

  task automatic hSetAddr(input logic [31:0] a);
    int w;
    wr32(2'b10, a, w);
    if (!eSplit || !ePick) erd = a;
    if (!eSplit || ePick)  ewr = a;
  endtask

  task automatic hChkAddr(input string tag);
    logic [31:0] v;
    int w;
    rd32(2'b10, v, w);
    chk(v == ((eSplit && ePick) ? ewr : erd), tag, v, (eSplit && ePick) ? ewr : erd);
  endtask

  task automatic hWrData(input bit inc, input logic [31:0] v, output int waits);
    wr32(inc ? 2'b01 : 2'b11, v, waits);
    expm[ewr[7:0]] = v;
    if (inc) ewr++;
  endtask

  task automatic hRdData(input bit inc, input string tag, output int waits);
    logic [31:0] v;
    rd32(inc ? 2'b01 : 2'b11, v, waits);
    chk(v == expm[erd[7:0]], tag, v, expm[erd[7:0]]);
    if (inc) erd++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : mainSeq
    logic [31:0] v;
    int w, sumW, mism;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin
      ram[i]  = seedWord(i);
      expm[i] = seedWord(i);
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk(hReady == 1'b1, "R1 ready after reset", 32'(hReady), 32'h1);
    chk(memReq == 1'b0, "R1 no request after reset", 32'(memReq), 32'h0);
    chk(hIrq == 1'b0 && cpuIrq == 1'b0, "R1 interrupts low", {hIrq, cpuIrq}, 32'h0);
    rd32(2'b00, v, w);
    chk(v == 32'h0, "R1 control reads zero", v, 32'h0);

    // R2 interrupts in both directions
    @(negedge clk); cpuSetHostIrq = 1'b1;
    @(negedge clk); cpuSetHostIrq = 1'b0;
    chk(hIrq == 1'b1 && hSel == 1'b0, "R2 host irq raised without select", 32'(hIrq), 32'h1);
    hSetCtrl(32'h0000_0001);
    @(negedge clk);
    chk(hIrq == 1'b0, "R2 host irq cleared by host", 32'(hIrq), 32'h0);
    hSetCtrl(32'h0000_0002);
    @(negedge clk);
    chk(cpuIrq == 1'b1, "R2 cpu irq raised by host", 32'(cpuIrq), 32'h1);
    rd32(2'b00, v, w);
    chk(v == 32'h2, "R2 control readback", v, 32'h2);
    @(negedge clk); cpuClrCpuIrq = 1'b1;
    @(negedge clk); cpuClrCpuIrq = 1'b0;
    chk(cpuIrq == 1'b0, "R2 cpu irq cleared by cpu", 32'(cpuIrq), 32'h0);

    // R3 register commits on the high half only
    hSetAddr(32'h0000_0010);
    begin
      logic [15:0] r;
      xfer(1'b0, 2'b10, 1'b0, 16'h55AA, r, w);
      xfer(1'b1, 2'b10, 1'b0, 16'h0, r, w);
      chk(r == 16'h0010, "R3 low half alone does not commit", 32'(r), 32'h10);
      xfer(1'b0, 2'b10, 1'b1, 16'h0001, r, w);
      erd = 32'h0001_55AA; ewr = 32'h0001_55AA;
    end
    hChkAddr("R3 address after both halves");

    // R4 split address registers
    hSetCtrl(32'h4);
    hSetAddr(32'h20);
    hSetCtrl(32'hC);
    hSetAddr(32'h40);
    hChkAddr("R4 write register view");
    hSetCtrl(32'h4);
    hChkAddr("R4 read register view");
    chk(erd == 32'h20 && ewr == 32'h40, "R4 model addresses", erd, 32'h20);
    for (int i = 0; i < 3; i++) hWrData(1'b1, 32'hBEEF_0000 + 32'(i), w);
    for (int i = 0; i < 3; i++) hRdData(1'b1, "R4 read stream independent", w);
    hSetCtrl(32'h0);

    // R6 fixed-address write waits for the previous one
    latFix = 3;
    hSetAddr(32'h50);
    hWrData(1'b0, 32'h1111_2222, w);
    hWrData(1'b0, 32'h3333_4444, w);
    chk(w > 0, "R6 second fixed write stalled", 32'(w), 32'h1);

    // R7 / R5 burst write through the FIFO
    hSetAddr(32'h80);
    sumW = 0;
    for (int i = 0; i < 8; i++) begin
      hWrData(1'b1, 32'hCAFE_0000 ^ (32'(i) << 4), w);
      sumW += w;
    end
    chk(sumW > 0, "R7 full write FIFO stalls host", 32'(sumW), 32'h1);
    chk(ewr == 32'h88, "R7 write address advanced", ewr, 32'h88);

    // R8 fixed read stalls then returns both halves
    hSetAddr(32'h84);
    hRdData(1'b0, "R8 fixed read value", w);
    chk(w > 0, "R8 first half stalls for memory", 32'(w), 32'h1);

    // R9 advancing read and repeated fixed reads
    latFix = -1;
    hSetAddr(32'h30);
    for (int i = 0; i < 5; i++) hRdData(1'b1, "R9 burst read value", w);
    hChkAddr("R9 read address advanced by five");
    hRdData(1'b0, "R9 fixed read after burst", w);
    hRdData(1'b0, "R9 fixed read repeats", w);
    hChkAddr("R9 fixed read leaves address");

    // R10 write flushes stale prefetch
    hSetAddr(32'h60);
    hRdData(1'b1, "R10 first word", w);
    repeat (20) @(negedge clk);
    hSetCtrl(32'hC);
    hSetAddr(32'h62);
    hWrData(1'b0, 32'hDEAD_F00D, w);
    hSetCtrl(32'h4);
    hRdData(1'b1, "R10 word before overwrite", w);
    hRdData(1'b1, "R10 overwritten word seen", w);
    hSetCtrl(32'h0);

    // random mix on a small window
    hSetAddr(32'h0);
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: hWrData(1'b1, $urandom, w);
        1: hWrData(1'b0, $urandom, w);
        2: hRdData(1'b1, "R9 random advancing read", w);
        3: hRdData(1'b0, "R8 random fixed read", w);
        4: hSetAddr(32'($urandom % 64));
        default: hChkAddr("R4 random address view");
      endcase
    end

    // R5 final memory image
    repeat (60) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== expm[i]) mism++;
    chk(mism == 0, "R5 memory image", 32'(mism), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule